// File: doc/BRIEF.md
# Receive Descriptor Chain Controller

This block walks a linked chain of receive buffer descriptors kept in a descriptor memory. Each arriving frame uses exactly one descriptor. The controller takes the descriptor at the current head and marks it complete in memory. It then records that descriptor's address as the last one it completed and advances the head to the descriptor's successor. When the successor link is null, the controller tags the descriptor as the end of the queue, sets the head to zero and stops. A head of zero means the channel is stalled until the host loads a new nonzero head.

The host reaches four registers through a small synchronous port. The head register sits at index 0 and the completion register at index 1. The frame-dropped-without-descriptor counter sits at index 2 and the frame-dropped-while-busy counter at index 3. The interrupt line is a level. It stays high while the host's acknowledged completion address differs from the address the hardware last completed, so a host that misses a completion is interrupted again. Descriptor memory is reached through a single-port request/ready handshake with any latency.

A descriptor is four 32-bit words at byte offsets 0x0 (link), 0x4 (buffer address), 0x8 (buffer length) and 0xC (flags). In the flags word, bit 31 is start-of-packet, bit 30 is end-of-packet, bit 29 is hardware ownership and bit 28 is end-of-queue.

Top module: `rxbd_queue_ctrl`

## Requirements
- R1: After reset, the head register (index 0) reads 0, the completion register (index 1) reads 0, both counters (indexes 2 and 3) read 0, `irq` is low and `hdp_err` is low.
- R2: For each accepted frame, the controller first reads the link word (offset 0x0) of the head descriptor and then its flags word (offset 0xC). If the link is null, it writes the flags back with bits 31, 30 and 28 set and bit 29 unchanged, then writes them again with bit 29 cleared. If the link is not null, it makes only one write: the flags with bits 31 and 30 set, bit 28 clear and bit 29 cleared.
- R3: After the flag writes, a read of register index 1 returns the retired descriptor's address, and the head register then holds the retired descriptor's link value.
- R4: When the retired descriptor's link is null, the head register becomes 0 and the channel goes idle.
- R5: While the channel is idle, a host write of a nonzero value to register index 0 loads the head and restarts reception from that descriptor.
- R6: A host write to register index 0 while the channel is active leaves the head unchanged and sets the sticky `hdp_err` output.
- R7: `irq` is high exactly when the hardware's last completed address differs from the value the host last wrote to index 1. A matching write drops it, and a non-matching write leaves it high.
- R8: A frame that arrives while the head is 0 is dropped without any memory access, and the counter at index 2 increments.
- R9: A frame that arrives while a previous descriptor is still being retired is dropped, and the counter at index 3 increments.
- R10: Each counter saturates at its all-ones value (CNT_W bits) and reads as zero after any read of it.
- R11: A memory request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ready`; the controller accepts any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_rd_en | input | 1 | Host register read strobe (clears a counter it reads) |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| frame_in | input | 1 | One-cycle pulse per arriving frame |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of descriptor word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Request completes this cycle |
| irq | output | 1 | Level interrupt, completion mismatch |
| hdp_err | output | 1 | Sticky: head written while active |

## Verification
On every cycle, the assertions check four properties. Memory requests stay steady while they wait. An end-of-queue tag is written only when the captured link was null. A head write while active always leaves the error flag set. The interrupt falls only after a host write to the completion register. They also check that no memory traffic occurs while the channel is idle and that a full counter does not wrap. The bench's scenarios show the rest: the exact order and values of descriptor writes under changing memory latency, head and completion contents after each retirement, restart after a stall, and counter clear-on-read and saturation.

// File: rtl/rxbd_pkg.sv
// Shared constants and types for the receive descriptor chain controller.
// Assumes descriptors are four 32-bit words with the flags word last.
package rxbd_pkg;
    localparam int WORD_W = 32;

    // Flag bit positions inside the descriptor flags word.
    localparam int FLG_SOP   = 31;
    localparam int FLG_EOP   = 30;
    localparam int FLG_OWNER = 29;
    localparam int FLG_EOQ   = 28;

    // Byte offsets of descriptor words.
    localparam logic [WORD_W-1:0] OFS_LINK  = 32'h0;
    localparam logic [WORD_W-1:0] OFS_FLAGS = 32'hC;

    // Host register indexes.
    localparam logic [1:0] REG_HEAD   = 2'd0;
    localparam logic [1:0] REG_COMPL  = 2'd1;
    localparam logic [1:0] REG_NODESC = 2'd2;
    localparam logic [1:0] REG_BUSY   = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LINK,
        ST_RD_FLAGS,
        ST_WR_EOQ,
        ST_WR_OWN,
        ST_COMPL,
        ST_HEAD
    } retire_state_e;
endpackage

// File: rtl/rxbd_sat_counter.sv
// Saturating event counter that clears when read.
// Assumes inc and clr are single-cycle strobes; an event in the clearing cycle is kept.
module rxbd_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Count events, stop at all-ones, reset to the pending event on read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= inc ? {{(W-1){1'b0}}, 1'b1} : '0;
        else if (inc && count != MAXV)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/rxbd_irq_track.sv
// Holds the hardware's last completed address and the host acknowledgement,
// and raises a level interrupt while they disagree.
// Assumes one hardware update and one host write may land in the same cycle.
module rxbd_irq_track #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_set,
    input  logic [AW-1:0] hw_addr,
    input  logic          host_set,
    input  logic [AW-1:0] host_addr,
    output logic [AW-1:0] hw_last,
    output logic          irq
);
    logic [AW-1:0] host_last;

    // Record the most recent completion from hardware.
    always_ff @(posedge clk) begin
        if (!rst_n)      hw_last <= '0;
        else if (hw_set) hw_last <= hw_addr;
    end

    // Record the most recent acknowledgement from the host.
    always_ff @(posedge clk) begin
        if (!rst_n)        host_last <= '0;
        else if (host_set) host_last <= host_addr;
    end

    // Interrupt level follows the mismatch.
    always_comb irq = (hw_last != host_last);
endmodule

// File: rtl/rxbd_retire_engine.sv
// Retires one descriptor per start pulse: reads link and flags, writes the
// end-of-queue tag (if the link is null), then clears ownership, then reports
// completion, then reports the new head. Memory accesses wait on mem_ready.
// Assumes start is only given while idle and the descriptor address is nonzero.
module rxbd_retire_engine
    import rxbd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] desc_addr,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ready,
    output logic          compl_wr,
    output logic [AW-1:0] compl_addr,
    output logic          head_wr,
    output logic [AW-1:0] link_q
);
    retire_state_e state;
    logic [AW-1:0] base_q;
    logic [31:0]   flags_q;
    logic          link_null;
    logic [31:0]   flags_eoq;
    logic [31:0]   flags_done;

    always_comb link_null = (link_q == '0);

    // Flag words for the two write steps.
    always_comb begin
        flags_eoq              = flags_q;
        flags_eoq[FLG_SOP]     = 1'b1;
        flags_eoq[FLG_EOP]     = 1'b1;
        flags_eoq[FLG_EOQ]     = link_null;
        flags_done             = flags_eoq;
        flags_done[FLG_OWNER]  = 1'b0;
    end

    // Sequence the retirement steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            base_q  <= '0;
            link_q  <= '0;
            flags_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    base_q <= desc_addr;
                    state  <= ST_RD_LINK;
                end
                ST_RD_LINK: if (mem_ready) begin
                    link_q <= mem_rdata[AW-1:0];
                    state  <= ST_RD_FLAGS;
                end
                ST_RD_FLAGS: if (mem_ready) begin
                    flags_q <= mem_rdata;
                    state   <= link_null ? ST_WR_EOQ : ST_WR_OWN;
                end
                ST_WR_EOQ: if (mem_ready) state <= ST_WR_OWN;
                ST_WR_OWN: if (mem_ready) state <= ST_COMPL;
                ST_COMPL:  state <= ST_HEAD;
                ST_HEAD:   state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port from the current step.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = base_q + OFS_FLAGS[AW-1:0];
        mem_wdata = flags_done;
        unique case (state)
            ST_RD_LINK:  begin mem_req = 1'b1; mem_addr = base_q + OFS_LINK[AW-1:0]; end
            ST_RD_FLAGS: mem_req = 1'b1;
            ST_WR_EOQ:   begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = flags_eoq; end
            ST_WR_OWN:   begin mem_req = 1'b1; mem_we = 1'b1; end
            default:     ;
        endcase
    end

    // Completion and head-update strobes.
    always_comb begin
        busy       = (state != ST_IDLE);
        compl_wr   = (state == ST_COMPL);
        compl_addr = base_q;
        head_wr    = (state == ST_HEAD);
    end
endmodule

// File: rtl/rxbd_queue_ctrl.sv
// Top of the receive descriptor chain controller: host registers, channel
// activity, drop counters, retirement engine and interrupt tracking.
// Assumes the host port is synchronous with a combinational read path.
module rxbd_queue_ctrl
    import rxbd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic          reg_rd_en,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          frame_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ready,
    output logic          irq,
    output logic          hdp_err
);
    logic [AW-1:0]    head_q;
    logic             active;
    logic             eng_busy;
    logic             eng_start;
    logic             compl_wr;
    logic [AW-1:0]    compl_addr;
    logic             head_wr;
    logic [AW-1:0]    link_q;
    logic [AW-1:0]    hw_last;
    logic             head_host_wr;
    logic             nodesc_inc;
    logic             busy_inc;
    logic [CNT_W-1:0] nodesc_cnt;
    logic [CNT_W-1:0] busy_cnt;

    // Classify each arriving frame.
    always_comb begin
        head_host_wr = reg_wr_en && (reg_addr == REG_HEAD);
        eng_start    = frame_in && active && !eng_busy;
        busy_inc     = frame_in && active && eng_busy;
        nodesc_inc   = frame_in && !active;
    end

    // Head pointer and channel activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            active  <= 1'b0;
            hdp_err <= 1'b0;
        end else if (head_wr) begin
            head_q <= link_q;
            active <= (link_q != '0);
        end else if (head_host_wr) begin
            if (active)
                hdp_err <= 1'b1;
            else if (reg_wdata[AW-1:0] != '0) begin
                head_q <= reg_wdata[AW-1:0];
                active <= 1'b1;
            end
        end
    end

    rxbd_retire_engine #(.AW(AW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (eng_start),
        .desc_addr  (head_q),
        .busy       (eng_busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .compl_wr   (compl_wr),
        .compl_addr (compl_addr),
        .head_wr    (head_wr),
        .link_q     (link_q)
    );

    rxbd_irq_track #(.AW(AW)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_set    (compl_wr),
        .hw_addr   (compl_addr),
        .host_set  (reg_wr_en && (reg_addr == REG_COMPL)),
        .host_addr (reg_wdata[AW-1:0]),
        .hw_last   (hw_last),
        .irq       (irq)
    );

    rxbd_sat_counter #(.W(CNT_W)) u_cnt_nodesc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (nodesc_inc),
        .clr   (reg_rd_en && (reg_addr == REG_NODESC)),
        .count (nodesc_cnt)
    );

    rxbd_sat_counter #(.W(CNT_W)) u_cnt_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (busy_inc),
        .clr   (reg_rd_en && (reg_addr == REG_BUSY)),
        .count (busy_cnt)
    );

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_HEAD:   reg_rdata[AW-1:0]    = head_q;
            REG_COMPL:  reg_rdata[AW-1:0]    = hw_last;
            REG_NODESC: reg_rdata[CNT_W-1:0] = nodesc_cnt;
            REG_BUSY:   reg_rdata[CNT_W-1:0] = busy_cnt;
            default:    ;
        endcase
    end
endmodule

// File: rtl/rxbd_queue_ctrl_chk.sv
// Property checker for rxbd_queue_ctrl, attached by bind.
module rxbd_queue_ctrl_chk #(
    parameter int AW    = 32,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic             reg_rd_en,
    input logic [1:0]       reg_addr,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ready,
    input logic             irq,
    input logic             hdp_err,
    input logic             active,
    input logic [AW-1:0]    link_q,
    input logic [CNT_W-1:0] nodesc_cnt
);
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    p_eoq_only_null_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_wdata[28]) |-> (link_q == '0));

    p_head_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 2'd0 && active) |=> hdp_err);

    p_irq_fall_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr_en && reg_addr == 2'd1));

    p_idle_no_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_req);

    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nodesc_cnt == {CNT_W{1'b1}} && !(reg_rd_en && reg_addr == 2'd2)) |=> (nodesc_cnt == {CNT_W{1'b1}}));
endmodule

bind rxbd_queue_ctrl rxbd_queue_ctrl_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_rd_en  (reg_rd_en),
    .reg_addr   (reg_addr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .irq        (irq),
    .hdp_err    (hdp_err),
    .active     (active),
    .link_q     (link_q),
    .nodesc_cnt (nodesc_cnt)
);

// File: tb/rxbd_queue_ctrl_tb.sv
module rxbd_queue_ctrl_tb;
    localparam int CNT_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_in = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        irq, hdp_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] mem [0:255];
    int          lat  = 0;
    int          wcnt = 0;

    // Expected memory writes: {address, data}.
    logic [63:0] exp_q [$];

    always #10 clk = ~clk;

    rxbd_queue_ctrl #(.AW(32), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_in(frame_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .irq(irq), .hdp_err(hdp_err)
    );

    // Memory model with latency rotating through 0..3 wait cycles.
    always @(posedge clk) begin
        if (mem_ready) begin
            mem_ready <= 1'b0;
            wcnt      <= 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ready <= 1'b1;
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                lat  <= (lat + 1) % 4;
                wcnt <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every completed memory write is compared with the scoreboard.
    always @(negedge clk) begin
        if (mem_req && mem_we && mem_ready) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2: unexpected write %h to %h, expected none", mem_wdata, mem_addr);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check("R2 write addr", mem_addr, e[63:32]);
                check("R2 write data", mem_wdata, e[31:0]);
            end
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic frame(input int n);
        @(negedge clk);
        frame_in = 1'b1;
        repeat (n) @(negedge clk);
        frame_in = 1'b0;
    endtask

    // Driver: queue expected writes for retiring descriptor at base.
    task automatic expect_retire(input logic [31:0] base, input bit last);
        if (last) exp_q.push_back({base + 32'hC, 32'hF000_0000});
        exp_q.push_back({base + 32'hC, last ? 32'hD000_0000 : 32'hC000_0000});
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // Chain 0x100 -> 0x110 -> 0x120 -> null; lone 0x200.
        mem[8'h40] = 32'h110; mem[8'h43] = 32'h2000_0000;
        mem[8'h44] = 32'h120; mem[8'h47] = 32'h2000_0000;
        mem[8'h48] = 32'h000; mem[8'h4B] = 32'h2000_0000;
        mem[8'h80] = 32'h000; mem[8'h83] = 32'h2000_0000;

        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);

        // R1 reset state
        reg_rd(2'd0, rd); check("R1 head", rd, 0);
        reg_rd(2'd1, rd); check("R1 compl", rd, 0);
        reg_rd(2'd2, rd); check("R1 nodesc", rd, 0);
        reg_rd(2'd3, rd); check("R1 busy", rd, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 hdp_err", {31'b0, hdp_err}, 0);

        // R8 frame with no descriptor
        frame(1); wait_cycles(10);
        check("R8 no write queued", exp_q.size(), 0);
        reg_rd(2'd2, rd); check("R8 nodesc count", rd, 1);
        reg_rd(2'd2, rd); check("R10 clear on read", rd, 0);

        // R5 load head while idle
        reg_wr(2'd0, 32'h100);
        reg_rd(2'd0, rd); check("R5 head loaded", rd, 32'h100);

        // First retirement, link not null
        expect_retire(32'h100, 1'b0);
        frame(1); wait_cycles(40);
        reg_rd(2'd0, rd); check("R3 head advanced", rd, 32'h110);
        reg_rd(2'd1, rd); check("R3 compl address", rd, 32'h100);
        check("R7 irq raised", {31'b0, irq}, 1);
        check("R2 flags in memory", mem[8'h43], 32'hC000_0000);

        // R6 head write while active
        reg_wr(2'd0, 32'h500);
        reg_rd(2'd0, rd); check("R6 head unchanged", rd, 32'h110);
        check("R6 hdp_err set", {31'b0, hdp_err}, 1);

        // R7 matching acknowledgement drops irq
        reg_wr(2'd1, 32'h100);
        check("R7 irq cleared", {31'b0, irq}, 0);

        // Second retirement then wrong acknowledgement
        expect_retire(32'h110, 1'b0);
        frame(1); wait_cycles(40);
        reg_rd(2'd1, rd); check("R3 compl second", rd, 32'h110);
        reg_wr(2'd1, 32'h100);
        check("R7 irq held on mismatch", {31'b0, irq}, 1);

        // R9 back-to-back frames, last descriptor, R4 end of queue
        expect_retire(32'h120, 1'b1);
        frame(2); wait_cycles(40);
        reg_rd(2'd3, rd); check("R9 busy drop count", rd, 1);
        reg_rd(2'd0, rd); check("R4 head zero", rd, 0);
        reg_rd(2'd1, rd); check("R4 compl last", rd, 32'h120);
        check("R4 eoq flags in memory", mem[8'h4B], 32'hD000_0000);
        frame(1); wait_cycles(10);
        reg_rd(2'd2, rd); check("R8 drop while stalled", rd, 1);

        // R5 restart after stall
        reg_wr(2'd0, 32'h200);
        reg_rd(2'd0, rd); check("R5 restart head", rd, 32'h200);
        expect_retire(32'h200, 1'b1);
        frame(1); wait_cycles(40);
        reg_rd(2'd0, rd); check("R5 restart done", rd, 0);
        reg_rd(2'd1, rd); check("R5 compl restart", rd, 32'h200);
        reg_wr(2'd1, 32'h200);
        check("R7 irq cleared restart", {31'b0, irq}, 0);

        // R10 saturation at all-ones
        for (int i = 0; i < 20; i++) frame(1);
        wait_cycles(2);
        reg_rd(2'd2, rd); check("R10 saturated", rd, 32'hF);
        reg_rd(2'd2, rd); check("R10 cleared after saturation", rd, 0);

        // R11 all queued writes happened through the handshake
        check("R11 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(negedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule